// File: doc/BRIEF.md
# Strobe Timing Tick Converter

This block turns a set of strobe timing targets for a parallel display bus, each given in picoseconds, into the packed tick-count words that a strobe generator consumes. The caller supplies the base clock period and ten times: chip-select assert and release, write-strobe assert and release, read-strobe assert and release, write cycle, read cycle, read access and chip-select pulse width. A single `start` pulse launches a conversion. `done` pulses once when it has finished, and the result words, the granularity bit and the error flag are valid from that cycle on.

The converter first uses a tick of one base period. It rounds each time up to whole ticks and repairs ordering violations, such as a release that comes no later than its assert. It then checks every field against its width. When some field does not fit, the whole pass is repeated with a tick of two base periods. Rounding uses one iterative restoring divider, shared across all ten fields, so a conversion takes a few hundred cycles. It is meant to run rarely, whenever the bus timing is reprogrammed.

Top module: `strobe_timing_conv`

## Requirements
- R1: Each time converts to ticks by ceiling division, ticks = ceil(time / (period × divider)), so a time one picosecond above a whole tick count gains one tick.
- R2: Divider 1 is tried first and divider 2 only if divider 1 fails. The first divider that succeeds is reported, with `gran` = divider − 1.
- R3: For each of the write, read and chip-select strobes, a release tick count that is not above its assert count is set to assert + 1.
- R4: After R3, the chip-select release is raised to at least the larger of the write release and the read release.
- R5: Access is raised to at least read assert + 1. Write cycle is raised to at least write release. Read cycle is raised to at least read release.
- R6: A divider fails if, after repair, any assert count exceeds 15 or any release, cycle, access or pulse count exceeds 63.
- R7: `word0` holds chip-select assert in bits 3:0 and chip-select release in 9:4. It holds write assert in 13:10, write release in 19:14, read assert in 23:20 and read release in 29:24. Bits 31:30 are zero.
- R8: `word1` holds write cycle in bits 5:0, read cycle in 11:6, pulse width in 17:12 and access in 27:22. Bits 21:18 and 31:28 are zero.
- R9: If both dividers fail, `done` pulses with `err` = 1, and `word0`, `word1` and `gran` are all zero.
- R10: After reset, `busy`, `done`, `err`, `gran` and both words are zero. `start` is accepted only while `busy` is low, and `busy` is high from the next cycle until the conversion ends. `done` is a one-cycle pulse with `busy` low. A `start` while `busy` is high is ignored.
- R11: `word0`, `word1`, `err` and `gran` change only in a `done` cycle. A `start` in the very cycle of `done` is accepted, and the previous result stays visible until the new `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion (taken while idle) |
| period_ps | input | PER_W | Base clock period in ps |
| cs_on_ps | input | TIME_W | Chip-select assert time |
| cs_off_ps | input | TIME_W | Chip-select release time |
| we_on_ps | input | TIME_W | Write strobe assert time |
| we_off_ps | input | TIME_W | Write strobe release time |
| re_on_ps | input | TIME_W | Read strobe assert time |
| re_off_ps | input | TIME_W | Read strobe release time |
| we_cyc_ps | input | TIME_W | Write cycle time |
| re_cyc_ps | input | TIME_W | Read cycle time |
| access_ps | input | TIME_W | Read access time |
| cs_pulse_ps | input | TIME_W | Chip-select pulse width |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Both dividers failed |
| gran | output | 1 | Divider − 1 of the reported result |
| word0 | output | 32 | Packed strobe edge word |
| word1 | output | 32 | Packed cycle/access word |

## Verification
The completion of one conversion and the acceptance of the next can fall in one cycle, because `busy` is already low while `done` pulses. The bench provokes this by raising `start` with new inputs at the moment it observes `done`. The reference model must then see the earlier result in that cycle, stable outputs throughout the following run, and the new result only at the second `done`. A `start` issued mid-run with different inputs is also checked: the next result must match the first request.

// File: rtl/strobe_conv_pkg.sv
package strobe_conv_pkg;
  localparam int NFIELD   = 10;
  localparam int SAT_W    = 7;
  localparam int EXT_W    = SAT_W + 1;
  localparam int ON_MAX   = 15;
  localparam int LONG_MAX = 63;

  typedef enum logic [3:0] {
    F_CS_ON, F_CS_OFF, F_WE_ON, F_WE_OFF, F_RE_ON,
    F_RE_OFF, F_WE_CYC, F_RE_CYC, F_ACCESS, F_PULSE
  } field_e;

  typedef logic [SAT_W-1:0] tick_t;
  typedef tick_t [NFIELD-1:0] tick_vec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_EVAL} conv_state_e;
endpackage

// File: rtl/strobe_ceil_div.sv
module strobe_ceil_div #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q, num_d, quo_q, quo_d;
  logic [DEN_W:0]   rem_q, rem_d, rem_sh, diff;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d, done_q, done_d, ge;

  always_comb begin
    rem_sh = {rem_q[DEN_W-1:0], num_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, den};
    diff   = rem_sh - {1'b0, den};
    num_d  = num_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;
    if (go) begin
      num_d = num;
      rem_d = '0;
      quo_d = '0;
      cnt_d = CNT_W'(NUM_W);
      run_d = 1'b1;
    end else if (run_q) begin
      num_d = num_q << 1;
      rem_d = ge ? diff : rem_sh;
      quo_d = {quo_q[NUM_W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      num_q  <= num_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign quo  = quo_q;
endmodule

// File: rtl/strobe_field_fix.sv
module strobe_field_fix
  import strobe_conv_pkg::*;
(
  input  tick_vec_t   ticks,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        ok
);
  logic [EXT_W-1:0] cs_on, cs_off, we_on, we_off, re_on, re_off;
  logic [EXT_W-1:0] we_cyc, re_cyc, acc, pulse;

  always_comb begin
    cs_on  = {1'b0, ticks[F_CS_ON]};
    we_on  = {1'b0, ticks[F_WE_ON]};
    re_on  = {1'b0, ticks[F_RE_ON]};
    pulse  = {1'b0, ticks[F_PULSE]};
    we_off = {1'b0, ticks[F_WE_OFF]};
    re_off = {1'b0, ticks[F_RE_OFF]};
    cs_off = {1'b0, ticks[F_CS_OFF]};
    acc    = {1'b0, ticks[F_ACCESS]};
    we_cyc = {1'b0, ticks[F_WE_CYC]};
    re_cyc = {1'b0, ticks[F_RE_CYC]};
    if (we_off <= we_on) we_off = we_on + 1'b1;
    if (re_off <= re_on) re_off = re_on + 1'b1;
    if (cs_off <= cs_on) cs_off = cs_on + 1'b1;
    if (cs_off < we_off) cs_off = we_off;
    if (cs_off < re_off) cs_off = re_off;
    if (acc <= re_on)    acc    = re_on + 1'b1;
    if (we_cyc < we_off) we_cyc = we_off;
    if (re_cyc < re_off) re_cyc = re_off;
    ok = (cs_on <= EXT_W'(ON_MAX)) && (we_on <= EXT_W'(ON_MAX)) &&
         (re_on <= EXT_W'(ON_MAX)) && (cs_off <= EXT_W'(LONG_MAX)) &&
         (we_off <= EXT_W'(LONG_MAX)) && (re_off <= EXT_W'(LONG_MAX)) &&
         (we_cyc <= EXT_W'(LONG_MAX)) && (re_cyc <= EXT_W'(LONG_MAX)) &&
         (acc <= EXT_W'(LONG_MAX)) && (pulse <= EXT_W'(LONG_MAX));
    word0 = {2'b00, re_off[5:0], re_on[3:0], we_off[5:0], we_on[3:0],
             cs_off[5:0], cs_on[3:0]};
    word1 = {4'b0000, acc[5:0], 4'b0000, pulse[5:0], re_cyc[5:0], we_cyc[5:0]};
  end
endmodule

// File: rtl/strobe_timing_conv.sv
module strobe_timing_conv
  import strobe_conv_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int TIME_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PER_W-1:0]  period_ps,
  input  logic [TIME_W-1:0] cs_on_ps,
  input  logic [TIME_W-1:0] cs_off_ps,
  input  logic [TIME_W-1:0] we_on_ps,
  input  logic [TIME_W-1:0] we_off_ps,
  input  logic [TIME_W-1:0] re_on_ps,
  input  logic [TIME_W-1:0] re_off_ps,
  input  logic [TIME_W-1:0] we_cyc_ps,
  input  logic [TIME_W-1:0] re_cyc_ps,
  input  logic [TIME_W-1:0] access_ps,
  input  logic [TIME_W-1:0] cs_pulse_ps,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              gran,
  output logic [31:0]       word0,
  output logic [31:0]       word1
);
  localparam int TICK_W = PER_W + 1;
  localparam int NUM_W  = TIME_W + 2;
  localparam int IDX_W  = $clog2(NFIELD);
  localparam logic [NUM_W-1:0] SAT_MAX = NUM_W'((1 << SAT_W) - 1);

  logic [NFIELD-1:0][TIME_W-1:0] in_vec, times_q, times_d;
  logic [PER_W-1:0]  period_q, period_d;
  conv_state_e       state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              div2_q, div2_d;
  tick_vec_t         ticks_q, ticks_d;
  logic [31:0]       w0_q, w0_d, w1_q, w1_d, fix_w0, fix_w1;
  logic              err_q, err_d, gran_q, gran_d, done_q, done_d, fix_ok;
  logic [TICK_W-1:0] tick;
  logic [NUM_W-1:0]  div_num, div_quo;
  logic              div_go, div_done;
  tick_t             quo_sat;

  assign in_vec[F_CS_ON]  = cs_on_ps;
  assign in_vec[F_CS_OFF] = cs_off_ps;
  assign in_vec[F_WE_ON]  = we_on_ps;
  assign in_vec[F_WE_OFF] = we_off_ps;
  assign in_vec[F_RE_ON]  = re_on_ps;
  assign in_vec[F_RE_OFF] = re_off_ps;
  assign in_vec[F_WE_CYC] = we_cyc_ps;
  assign in_vec[F_RE_CYC] = re_cyc_ps;
  assign in_vec[F_ACCESS] = access_ps;
  assign in_vec[F_PULSE]  = cs_pulse_ps;

  assign tick    = div2_q ? {period_q, 1'b0} : {1'b0, period_q};
  assign div_num = NUM_W'(times_q[idx_q]) + NUM_W'(tick) - NUM_W'(1);
  assign div_go  = (state_q == ST_LOAD);
  assign quo_sat = (div_quo > SAT_MAX) ? '1 : div_quo[SAT_W-1:0];

  strobe_ceil_div #(.NUM_W(NUM_W), .DEN_W(TICK_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(tick),
    .done(div_done), .quo(div_quo)
  );

  strobe_field_fix u_fix (
    .ticks(ticks_q), .word0(fix_w0), .word1(fix_w1), .ok(fix_ok)
  );

  always_comb begin
    state_d  = state_q;
    times_d  = times_q;
    period_d = period_q;
    idx_d    = idx_q;
    div2_d   = div2_q;
    ticks_d  = ticks_q;
    w0_d     = w0_q;
    w1_d     = w1_q;
    err_d    = err_q;
    gran_d   = gran_q;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        times_d  = in_vec;
        period_d = period_ps;
        idx_d    = '0;
        div2_d   = 1'b0;
        state_d  = ST_LOAD;
      end
      ST_LOAD: state_d = ST_WAIT;
      ST_WAIT: if (div_done) begin
        ticks_d[idx_q] = quo_sat;
        if (idx_q == IDX_W'(NFIELD - 1)) begin
          state_d = ST_EVAL;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = ST_LOAD;
        end
      end
      ST_EVAL: begin
        if (fix_ok) begin
          w0_d    = fix_w0;
          w1_d    = fix_w1;
          gran_d  = div2_q;
          err_d   = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (!div2_q) begin
          div2_d  = 1'b1;
          idx_d   = '0;
          state_d = ST_LOAD;
        end else begin
          w0_d    = '0;
          w1_d    = '0;
          gran_d  = 1'b0;
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      times_q  <= '0;
      period_q <= '0;
      idx_q    <= '0;
      div2_q   <= 1'b0;
      ticks_q  <= '0;
      w0_q     <= '0;
      w1_q     <= '0;
      err_q    <= 1'b0;
      gran_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      times_q  <= times_d;
      period_q <= period_d;
      idx_q    <= idx_d;
      div2_q   <= div2_d;
      ticks_q  <= ticks_d;
      w0_q     <= w0_d;
      w1_q     <= w1_d;
      err_q    <= err_d;
      gran_q   <= gran_d;
      done_q   <= done_d;
    end
  end

  assign busy  = (state_q != ST_IDLE);
  assign done  = done_q;
  assign err   = err_q;
  assign gran  = gran_q;
  assign word0 = w0_q;
  assign word1 = w1_q;
endmodule

// File: rtl/strobe_timing_conv_chk.sv
module strobe_timing_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        gran,
  input logic [31:0] word0,
  input logic [31:0] word1
);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(word0) && $stable(word1) && $stable(err) && $stable(gran)));
  assert_fail_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (word0 == 32'd0 && word1 == 32'd0 && !gran));
  assert_off_after_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word0[9:4] > {2'b00, word0[3:0]} &&
                        word0[19:14] > {2'b00, word0[13:10]} &&
                        word0[29:24] > {2'b00, word0[23:20]}));
  assert_cs_cover_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word0[9:4] >= word0[19:14] && word0[9:4] >= word0[29:24]));
  assert_min_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word1[27:22] > {2'b00, word0[23:20]} &&
                        word1[5:0] >= word0[19:14] && word1[11:6] >= word0[29:24]));
  assert_spare_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (word1[21:18] == 4'd0 && word1[31:28] == 4'd0 && word0[31:30] == 2'd0));
endmodule

bind strobe_timing_conv strobe_timing_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .gran(gran), .word0(word0), .word1(word1)
);

// File: tb/sim_strobe_timing_conv.sv
module sim_strobe_timing_conv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] period_ps = '0;
  logic [19:0] t_in [10];
  logic        busy, done, err, gran;
  logic [31:0] word0, word1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  bit          q_err[$];
  bit          q_gran[$];
  logic [31:0] q_w0[$];
  logic [31:0] q_w1[$];
  string       q_tag[$];

  logic [31:0] last_w0, last_w1;
  logic        last_err, last_gran;

  always #4 clk = ~clk;

  initial for (int i = 0; i < 10; i++) t_in[i] = '0;

  strobe_timing_conv u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .period_ps(period_ps),
    .cs_on_ps(t_in[0]), .cs_off_ps(t_in[1]), .we_on_ps(t_in[2]),
    .we_off_ps(t_in[3]), .re_on_ps(t_in[4]), .re_off_ps(t_in[5]),
    .we_cyc_ps(t_in[6]), .re_cyc_ps(t_in[7]), .access_ps(t_in[8]),
    .cs_pulse_ps(t_in[9]), .busy(busy), .done(done), .err(err),
    .gran(gran), .word0(word0), .word1(word1)
  );

  task automatic check(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // index order: cs_on cs_off we_on we_off re_on re_off we_cyc re_cyc access pulse
  function automatic void ref_model(input int p, input int t[10], output bit e,
                                    output logic [31:0] w0, output logic [31:0] w1,
                                    output bit g);
    e = 1'b1; w0 = '0; w1 = '0; g = 1'b0;
    for (int d = 1; d <= 2; d++) begin
      int tk, con, coff, won, woff, ron, roff, wc, rc, ac, pu;
      tk   = p * d;
      con  = (t[0] + tk - 1) / tk;  coff = (t[1] + tk - 1) / tk;
      won  = (t[2] + tk - 1) / tk;  woff = (t[3] + tk - 1) / tk;
      ron  = (t[4] + tk - 1) / tk;  roff = (t[5] + tk - 1) / tk;
      wc   = (t[6] + tk - 1) / tk;  rc   = (t[7] + tk - 1) / tk;
      ac   = (t[8] + tk - 1) / tk;  pu   = (t[9] + tk - 1) / tk;
      if (woff <= won) woff = won + 1;
      if (roff <= ron) roff = ron + 1;
      if (coff <= con) coff = con + 1;
      if (coff < woff) coff = woff;
      if (coff < roff) coff = roff;
      if (ac <= ron) ac = ron + 1;
      if (wc < woff) wc = woff;
      if (rc < roff) rc = roff;
      if (con <= 15 && won <= 15 && ron <= 15 && coff <= 63 && woff <= 63 &&
          roff <= 63 && wc <= 63 && rc <= 63 && ac <= 63 && pu <= 63) begin
        e  = 1'b0;
        g  = (d == 2);
        w0 = 32'(con) | 32'(coff) << 4 | 32'(won) << 10 | 32'(woff) << 14 |
             32'(ron) << 20 | 32'(roff) << 24;
        w1 = 32'(wc) | 32'(rc) << 6 | 32'(pu) << 12 | 32'(ac) << 22;
        return;
      end
    end
  endfunction

  // called at a negedge; drives inputs, pulses start for one cycle
  task automatic launch(input int p, input int t[10], input string tag);
    bit e, g;
    logic [31:0] w0, w1;
    period_ps = 16'(p);
    for (int i = 0; i < 10; i++) t_in[i] = 20'(t[i]);
    if (!busy) begin
      ref_model(p, t, e, w0, w1, g);
      q_err.push_back(e); q_gran.push_back(g);
      q_w0.push_back(w0); q_w1.push_back(w1); q_tag.push_back(tag);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // per-clock comparison against the model queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        check(!busy, "R10 busy low with done", 32'(busy), 32'd0);
        if (q_w0.size() == 0) begin
          check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
        end else begin
          automatic bit e = q_err.pop_front();
          automatic bit g = q_gran.pop_front();
          automatic logic [31:0] w0 = q_w0.pop_front();
          automatic logic [31:0] w1 = q_w1.pop_front();
          automatic string tg = q_tag.pop_front();
          check(err == e,   {tg, " err R9"},   32'(err), 32'(e));
          check(gran == g,  {tg, " gran R2"},  32'(gran), 32'(g));
          check(word0 == w0, {tg, " word0 R7"}, word0, w0);
          check(word1 == w1, {tg, " word1 R8"}, word1, w1);
        end
      end else begin
        check(word0 == last_w0 && word1 == last_w1 && err == last_err &&
              gran == last_gran, "R11 outputs held", word0, last_w0);
      end
      last_w0 = word0; last_w1 = word1; last_err = err; last_gran = gran;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    last_w0 = '0; last_w1 = '0; last_err = 1'b0; last_gran = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && !gran, "R10 reset flags", {28'd0, busy, done, err, gran}, 32'd0);
    check(word0 == 0 && word1 == 0, "R10 reset words", word0 | word1, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R7 R8 plain values
    launch(1000, '{2000, 9000, 1500, 5000, 3000, 8000, 10000, 12000, 6000, 4000}, "R1 R7 R8 basic");
    wait_done();
    // R3 R4 R5 ordering repairs
    launch(1000, '{3000, 1000, 4000, 2000, 5000, 5000, 1000, 1000, 2000, 0}, "R3 R4 R5 repair");
    wait_done();
    // R2 R6 write cycle too long at divider 1, fits at divider 2
    launch(1000, '{1000, 6000, 1000, 4000, 2000, 5000, 100000, 9000, 3000, 2000}, "R2 R6 retry");
    wait_done();
    // R6 boundary: assert 15 and release 63 fit at divider 1
    launch(1000, '{15000, 20000, 2000, 63000, 1000, 3000, 63000, 5000, 63000, 63000}, "R6 edge fit");
    wait_done();
    // R6 read assert 16 fails at divider 1
    launch(1000, '{1000, 2000, 1000, 2000, 16000, 20000, 3000, 30000, 20000, 1000}, "R6 R2 on16");
    wait_done();
    // R9 pulse too long for both dividers
    launch(1000, '{1000, 2000, 1000, 2000, 1000, 2000, 3000, 3000, 3000, 200000}, "R9 fail");
    wait_done();
    // R1 ceiling at odd period and divider-2 rounding
    launch(700, '{701, 1400, 1401, 2099, 700, 2100, 44801, 7000, 1500, 699}, "R1 ceil");
    wait_done();
    // R10 start while busy ignored
    launch(1000, '{2000, 4000, 1000, 3000, 1000, 2000, 5000, 5000, 3000, 1000}, "R10 ignore");
    repeat (5) @(negedge clk);
    launch(900, '{9000, 9000, 9000, 9000, 9000, 9000, 9000, 9000, 9000, 9000}, "R10 dropped");
    wait_done();
    // R11 restart in the done cycle
    launch(1000, '{1000, 3000, 2000, 4000, 1000, 5000, 6000, 7000, 2000, 3000}, "R11 first");
    while (!done) @(negedge clk);
    launch(1000, '{1000, 2000, 1000, 2000, 70000, 2000, 3000, 3000, 3000, 1000}, "R11 second R9");
    wait_done();
    repeat (3) @(negedge clk);
    check(q_w0.size() == 0, "R10 all results seen", 32'(q_w0.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule